// File: doc/BRIEF.md
# External Bus Access Sequencer

This block connects a DSP core's three internal request paths (program fetch, data read, data write) to one shared external bus with a 16-bit address and 16-bit data path. The core may raise any mix of the three requests in one machine cycle. The sequencer latches them together and plays them out one at a time on the external bus. A data write always goes first, then the data read, then the program fetch. Requests that are not raised take no bus time. For each external cycle the sequencer drives one active-low space select (program, data or I/O), a read/write line, a strobe and an active-low global-memory request.

An 8-bit global-window register, written by the core, marks part of the upper half of data space as global. A data-space access at or above 0x8000 whose upper address byte is at least the register value pulls the global request low. A register value of zero turns the window off. The register value in force at acceptance governs the whole sequence.

The `stall` output is the back-pressure signal. While it is high, the core must hold its requests steady. Requests presented while a sequence is running are ignored. `stall` is low in the final strobe clock of a sequence, so the core may present new requests at the next edge. Read data comes back on two separate outputs, one for data reads and one for fetches. Each has its own one-clock valid pulse, in the clock after the strobe that sampled it. The external data path is split into an output, an output enable and an input, so that the pad ring can build the tri-state driver.

Top module: `xbus_seq`

## Requirements
- R1: The latched requests run on the bus in the fixed order data write, then data read, then program fetch. A request not raised at acceptance takes no bus cycle.
- R2: Each external access lasts exactly two clocks. In the address clock `strb_n` is high; in the strobe clock it is low. Address, select, `rw` and `br_n` stay unchanged across both clocks.
- R3: During an access exactly one select is low: `ps_n` for a fetch, `is_n` for a read or write flagged as I/O, and `ds_n` otherwise. When the bus is idle, all three selects and `strb_n` are high.
- R4: `rw` is 0 for a write access and 1 for a read access or fetch.
- R5: `bus_doe` is 1, and `bus_dout` carries the latched write data, only during the two clocks of a write access. Otherwise `bus_doe` is 0.
- R6: `br_n` is 0 only during a data-space (not I/O) read or write whose address has bit 15 set and an upper byte greater than or equal to the global-window register. A register value of 0 disables it, fetches never assert it, and the register value at acceptance applies (a write in the same cycle takes effect for the next sequence).
- R7: `stall` is 1 in the accept cycle and in every later cycle of the sequence except the final strobe clock, in which it is 0. With no request and an idle bus, `stall` is 0.
- R8: Request inputs that change while a sequence is in progress have no effect on that sequence's bus cycles.
- R9: `bus_din` is sampled at the end of a read's strobe clock. In the next clock it appears on `dr_rdata` with `dr_rvalid` = 1, or on `pf_rdata` with `pf_rvalid` = 1 for a fetch. Each valid is a single-clock pulse.
- R10: After reset the bus is idle, `stall` and both valids are 0, and the global window is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pf_req | input | 1 | Program-fetch request |
| pf_addr | input | 16 | Program-fetch address |
| dr_req | input | 1 | Data-read request |
| dr_addr | input | 16 | Data-read address |
| dr_io | input | 1 | Data read targets I/O space |
| dw_req | input | 1 | Data-write request |
| dw_addr | input | 16 | Data-write address |
| dw_data | input | 16 | Data-write value |
| dw_io | input | 1 | Data write targets I/O space |
| greg_we | input | 1 | Global-window register write enable |
| greg_wdata | input | 8 | Global-window register write value |
| stall | output | 1 | Core hold request |
| dr_rvalid | output | 1 | Data-read result valid pulse |
| dr_rdata | output | 16 | Data-read result |
| pf_rvalid | output | 1 | Fetch result valid pulse |
| pf_rdata | output | 16 | Fetch result |
| bus_addr | output | 16 | External address |
| bus_dout | output | 16 | External write data |
| bus_doe | output | 1 | External data output enable |
| bus_din | input | 16 | External read data |
| ps_n | output | 1 | Program space select, active low |
| ds_n | output | 1 | Data space select, active low |
| is_n | output | 1 | I/O space select, active low |
| rw | output | 1 | 1 = read, 0 = write |
| strb_n | output | 1 | Access strobe, active low |
| br_n | output | 1 | Global request, active low |

## Verification
The bench runs all eight combinations of the three requests. Comparing these shows that absent accesses are skipped and the write/read/fetch order holds for every subset. Each combination is repeated with addresses just below 0x8000, at 0x8000, at a mid value, and at 0xFF00, against window settings of 0, 0x01, 0x80, 0x90, 0xC0 and 0xFF. This separates the equal-to-threshold boundary from the strict-greater case and shows the disable value. Alternating the I/O flags tells a select-decode error apart from a global-decode error. Scrambled requests held during each sequence, plus a window write in an accept cycle, show that in-flight state is frozen at acceptance.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADR  = 2'd1,
    PH_STB  = 2'd2
  } phase_e;

  // Slot index doubles as bus priority: lowest index runs first.
  localparam int NSLOT   = 3;
  localparam int SLOT_DW = 0;
  localparam int SLOT_DR = 1;
  localparam int SLOT_PF = 2;
endpackage

// File: rtl/xbus_pick.sv
module xbus_pick #(
  parameter int N = 3
) (
  input  logic [N-1:0] pend,
  output logic [N-1:0] grant
);
  // Fixed priority: lowest set bit wins.
  for (genvar i = 0; i < N; i++) begin : g_pri
    if (i == 0) begin : g_first
      assign grant[i] = pend[i];
    end else begin : g_rest
      assign grant[i] = pend[i] & ~(|pend[i-1:0]);
    end
  end
endmodule

// File: rtl/xbus_glob_dec.sv
module xbus_glob_dec #(
  parameter int AW = 16,
  parameter int GW = 8
) (
  input  logic [AW-1:0] addr,
  input  logic [GW-1:0] gsel,
  input  logic          is_data,
  output logic          glob
);
  logic [GW-1:0] upper;
  assign upper = addr[AW-1 -: GW];
  // Upper half only, window enabled, upper field at or past threshold.
  assign glob = is_data & addr[AW-1] & (|gsel) & (upper >= gsel);
endmodule

// File: rtl/xbus_phase.sv
module xbus_phase
  import xbus_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic last,
  output logic idle,
  output logic in_adr,
  output logic in_stb
);
  phase_e ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE;
    end else begin
      case (ph)
        PH_IDLE: if (start) ph <= PH_ADR;
        PH_ADR:  ph <= PH_STB;
        PH_STB:  ph <= last ? PH_IDLE : PH_ADR;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign idle   = (ph == PH_IDLE);
  assign in_adr = (ph == PH_ADR);
  assign in_stb = (ph == PH_STB);
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pf_req,
  input  logic [AW-1:0] pf_addr,
  input  logic          dr_req,
  input  logic [AW-1:0] dr_addr,
  input  logic          dr_io,
  input  logic          dw_req,
  input  logic [AW-1:0] dw_addr,
  input  logic [DW-1:0] dw_data,
  input  logic          dw_io,
  input  logic          greg_we,
  input  logic [GW-1:0] greg_wdata,
  output logic          stall,
  output logic          dr_rvalid,
  output logic [DW-1:0] dr_rdata,
  output logic          pf_rvalid,
  output logic [DW-1:0] pf_rdata,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  input  logic [DW-1:0] bus_din,
  output logic          ps_n,
  output logic          ds_n,
  output logic          is_n,
  output logic          rw,
  output logic          strb_n,
  output logic          br_n
);
  localparam int NS = NSLOT;

  logic [GW-1:0] greg;
  logic [NS-1:0] req_vec, pend, cur;
  logic [AW-1:0] a_in  [NS];
  logic [AW-1:0] a_lat [NS];
  logic [NS-1:0] io_in, io_lat, glob_in, glob_lat;
  logic [DW-1:0] wd_lat;
  logic          idle, in_adr, in_stb, active, start, last;
  logic [AW-1:0] sel_addr;

  // Request vector in bus-priority order.
  assign req_vec[SLOT_DW] = dw_req;
  assign req_vec[SLOT_DR] = dr_req;
  assign req_vec[SLOT_PF] = pf_req;
  assign a_in[SLOT_DW]    = dw_addr;
  assign a_in[SLOT_DR]    = dr_addr;
  assign a_in[SLOT_PF]    = pf_addr;
  assign io_in[SLOT_DW]   = dw_io;
  assign io_in[SLOT_DR]   = dr_io;
  assign io_in[SLOT_PF]   = 1'b0;

  // Global-window register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       greg <= '0;
    else if (greg_we) greg <= greg_wdata;
  end

  // One decoder per slot; the fetch slot is never data space.
  for (genvar s = 0; s < NS; s++) begin : g_dec
    xbus_glob_dec #(.AW(AW), .GW(GW)) u_dec (
      .addr    (a_in[s]),
      .gsel    (greg),
      .is_data ((s != SLOT_PF) && !io_in[s]),
      .glob    (glob_in[s])
    );
  end

  xbus_pick #(.N(NS)) u_pick (
    .pend  (pend),
    .grant (cur)
  );

  assign start = idle & (|req_vec);
  assign last  = ~(|(pend & ~cur));

  xbus_phase u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .last   (last),
    .idle   (idle),
    .in_adr (in_adr),
    .in_stb (in_stb)
  );

  assign active = in_adr | in_stb;

  // Capture the whole request set at acceptance; retire one slot per strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= '0;
      io_lat   <= '0;
      glob_lat <= '0;
      wd_lat   <= '0;
      for (int i = 0; i < NS; i++) a_lat[i] <= '0;
    end else if (start) begin
      pend     <= req_vec;
      io_lat   <= io_in;
      glob_lat <= glob_in;
      wd_lat   <= dw_data;
      for (int i = 0; i < NS; i++) a_lat[i] <= a_in[i];
    end else if (in_stb) begin
      pend <= pend & ~cur;
    end
  end

  always_comb begin
    sel_addr = '0;
    for (int i = 0; i < NS; i++)
      if (cur[i]) sel_addr = sel_addr | a_lat[i];
  end

  // Bus outputs decoded from registered state only.
  assign bus_addr = active ? sel_addr : '0;
  assign ps_n     = ~(active & cur[SLOT_PF]);
  assign ds_n     = ~(active & |(cur & ~io_lat & ~(NS'(1) << SLOT_PF)));
  assign is_n     = ~(active & |(cur & io_lat));
  assign rw       = ~(active & cur[SLOT_DW]);
  assign strb_n   = ~in_stb;
  assign br_n     = ~(active & |(cur & glob_lat));
  assign bus_doe  = active & cur[SLOT_DW];
  assign bus_dout = bus_doe ? wd_lat : '0;

  assign stall = start | (active & ~(in_stb & last));

  // Read return.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_rvalid <= 1'b0;
      pf_rvalid <= 1'b0;
      dr_rdata  <= '0;
      pf_rdata  <= '0;
    end else begin
      dr_rvalid <= in_stb & cur[SLOT_DR];
      pf_rvalid <= in_stb & cur[SLOT_PF];
      if (in_stb & cur[SLOT_DR]) dr_rdata <= bus_din;
      if (in_stb & cur[SLOT_PF]) pf_rdata <= bus_din;
    end
  end
endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stall,
  input logic          dr_rvalid,
  input logic          pf_rvalid,
  input logic [AW-1:0] bus_addr,
  input logic          bus_doe,
  input logic          ps_n,
  input logic          ds_n,
  input logic          is_n,
  input logic          rw,
  input logic          strb_n,
  input logic          br_n
);
  // R3: never more than one select active
  a_r3_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ps_n, ds_n, is_n}) >= 2);

  // R3: strobe only while a select is active
  a_r3_strobe_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !strb_n |-> !(ps_n & ds_n & is_n));

  // R2: strobe preceded by an address clock with the same address
  a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    !strb_n |-> ($past(strb_n) && $stable(bus_addr)));

  // R2: strobe lasts one clock
  a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    !strb_n |=> strb_n);

  // R5: data driven only on writes
  a_r5_doe_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> !rw);

  // R6: global request only with data-space select
  a_r6_global_data: assert property (@(posedge clk) disable iff (!rst_n)
    !br_n |-> !ds_n);

  // R7: the address clock always stalls the core
  a_r7_addr_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_n && !(ps_n & ds_n & is_n)) |-> stall);

  // R9: each valid follows a strobe clock
  a_r9_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_rvalid || pf_rvalid) |-> $past(!strb_n));

  // R9: the two returns never coincide
  a_r9_single_return: assert property (@(posedge clk) disable iff (!rst_n)
    !(dr_rvalid && pf_rvalid));
endmodule

bind xbus_seq xbus_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/xbus_seq_tb.sv
`timescale 1ns/1ps
module xbus_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pf_req = 0, dr_req = 0, dw_req = 0, dr_io = 0, dw_io = 0;
  logic [15:0] pf_addr = 0, dr_addr = 0, dw_addr = 0, dw_data = 0;
  logic        greg_we = 0;
  logic [7:0]  greg_wdata = 0;
  logic        stall, dr_rvalid, pf_rvalid, bus_doe;
  logic [15:0] dr_rdata, pf_rdata, bus_addr, bus_dout, bus_din;
  logic        ps_n, ds_n, is_n, rw, strb_n, br_n;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] gcur = 8'h00;

  always #2.5 clk = ~clk;

  xbus_seq u_dut (
    .clk(clk), .rst_n(rst_n),
    .pf_req(pf_req), .pf_addr(pf_addr),
    .dr_req(dr_req), .dr_addr(dr_addr), .dr_io(dr_io),
    .dw_req(dw_req), .dw_addr(dw_addr), .dw_data(dw_data), .dw_io(dw_io),
    .greg_we(greg_we), .greg_wdata(greg_wdata),
    .stall(stall),
    .dr_rvalid(dr_rvalid), .dr_rdata(dr_rdata),
    .pf_rvalid(pf_rvalid), .pf_rdata(pf_rdata),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
    .ps_n(ps_n), .ds_n(ds_n), .is_n(is_n), .rw(rw), .strb_n(strb_n), .br_n(br_n)
  );

  // External memory model: content is a function of address and space.
  function automatic logic [15:0] mem_val(input logic [15:0] a, input int sp);
    case (sp)
      0:       return a ^ 16'hA5A5;  // program
      1:       return a ^ 16'h3C3C;  // data
      default: return a ^ 16'h0F0F;  // I/O
    endcase
  endfunction

  always_comb begin
    if (!ps_n)      bus_din = mem_val(bus_addr, 0);
    else if (!ds_n) bus_din = mem_val(bus_addr, 1);
    else if (!is_n) bus_din = mem_val(bus_addr, 2);
    else            bus_din = 16'hDEAD;
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_glob(input logic [15:0] a, input logic [7:0] g);
    return a[15] && (g != 8'h00) && (a[15:8] >= g);
  endfunction

  task automatic set_greg(input logic [7:0] v);
    @(negedge clk);
    greg_we = 1; greg_wdata = v;
    @(negedge clk);
    greg_we = 0;
    gcur = v;
  endtask

  task automatic check_idle(input string tag);
    check("R3", {tag, " idle selects"}, {ps_n, ds_n, is_n, strb_n}, 4'hF);
    check("R5", {tag, " idle doe"}, bus_doe, 0);
    check("R6", {tag, " idle br_n"}, br_n, 1);
  endtask

  // Runs one request set and checks every clock of the resulting sequence.
  task automatic run_seq(input logic p, input logic d, input logic w,
                         input logic [15:0] pa, input logic [15:0] da,
                         input logic [15:0] wa, input logic [15:0] wd,
                         input logic dio, input logic wio,
                         input logic gwr, input logic [7:0] gnew);
    logic [2:0]  pres;
    logic [15:0] addr [3];
    int          prev;
    logic [7:0]  gacc;
    pres = {p, d, w};
    addr[0] = wa; addr[1] = da; addr[2] = pa;
    gacc = gcur;
    @(negedge clk);
    pf_req = p; pf_addr = pa; dr_req = d; dr_addr = da; dr_io = dio;
    dw_req = w; dw_addr = wa; dw_data = wd; dw_io = wio;
    if (gwr) begin greg_we = 1; greg_wdata = gnew; end
    #1;
    check("R7", "accept stall", stall, |pres);
    if (pres == 3'b000) begin
      check_idle("R1 none");
      @(negedge clk);
      if (gwr) begin greg_we = 0; gcur = gnew; end
      #1;
      check("R1", "no request no cycle", {ps_n, ds_n, is_n, strb_n}, 4'hF);
      check("R7", "no request stall", stall, 0);
      return;
    end
    prev = -1;
    for (int k = 0; k < 3; k++) begin
      if (pres[k]) begin
        logic       lastk;
        logic [2:0] sel;
        logic       gl;
        lastk = (k == 2) || (pres[2:0] >> (k + 1)) == 0;
        if (k == 2)      sel = 3'b011;
        else if ((k == 1 && dio) || (k == 0 && wio)) sel = 3'b110;
        else             sel = 3'b101;
        gl = (k != 2) && sel == 3'b101 && exp_glob(addr[k], gacc);
        // address clock
        @(negedge clk);
        if (gwr) begin greg_we = 0; gcur = gnew; end
        // R8: scramble requests while busy
        pf_req = ~p; dr_req = ~d; dw_req = ~w;
        pf_addr = ~pa; dr_addr = ~da; dw_addr = ~wa; dw_data = ~wd;
        dr_io = ~dio; dw_io = ~wio;
        #1;
        check("R1", $sformatf("order slot %0d addr", k), bus_addr, addr[k]);
        check("R3", $sformatf("slot %0d select", k), {ps_n, ds_n, is_n}, sel);
        check("R4", $sformatf("slot %0d rw", k), rw, k != 0);
        check("R2", "address clock strobe high", strb_n, 1);
        check("R6", $sformatf("slot %0d br_n", k), br_n, !gl);
        check("R5", "doe addr clock", bus_doe, k == 0);
        if (k == 0) check("R5", "write data", bus_dout, wd);
        check("R7", "stall in address clock", stall, 1);
        check("R9", "dr valid", dr_rvalid, prev == 1);
        check("R9", "pf valid", pf_rvalid, prev == 2);
        if (prev == 1) check("R9", "dr data", dr_rdata, mem_val(da, dio ? 2 : 1));
        // strobe clock
        @(negedge clk);
        if (lastk) begin pf_req = 0; dr_req = 0; dw_req = 0; end
        #1;
        check("R2", "strobe low", strb_n, 0);
        check("R8", "addr held in strobe", bus_addr, addr[k]);
        check("R2", "select held", {ps_n, ds_n, is_n}, sel);
        check("R6", "br_n held", br_n, !gl);
        check("R5", "doe strobe clock", bus_doe, k == 0);
        check("R7", "stall in strobe", stall, !lastk);
        check("R9", "no valid in strobe", {dr_rvalid, pf_rvalid}, 0);
        prev = k;
      end
    end
    @(negedge clk);
    #1;
    check_idle("R1 end");
    check("R7", "stall after", stall, 0);
    check("R9", "final dr valid", dr_rvalid, prev == 1);
    check("R9", "final pf valid", pf_rvalid, prev == 2);
    if (prev == 1) check("R9", "final dr data", dr_rdata, mem_val(da, dio ? 2 : 1));
    if (prev == 2) check("R9", "pf data", pf_rdata, mem_val(pa, 0));
    @(negedge clk);
    #1;
    check("R9", "valid is a pulse", {dr_rvalid, pf_rvalid}, 0);
  endtask

  initial begin
    logic [15:0] das [4];
    logic [7:0]  gv [6];
    das[0] = 16'h7FFF; das[1] = 16'h8000; das[2] = 16'h9080; das[3] = 16'hFF00;
    gv[0] = 8'h00; gv[1] = 8'h80; gv[2] = 8'h90; gv[3] = 8'hC0; gv[4] = 8'hFF; gv[5] = 8'h01;
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    check_idle("R10");
    check("R10", "stall", stall, 0);
    check("R10", "valids", {dr_rvalid, pf_rvalid}, 0);
    @(negedge clk);
    rst_n = 1;
    // R6: with window reset to 0, the top address is not global
    run_seq(0, 1, 0, 16'h0, 16'hFFFF, 16'h0, 16'h0, 0, 0, 0, 8'h0);
    for (int g = 0; g < 6; g++) begin
      set_greg(gv[g]);
      for (int c = 0; c < 8; c++) begin
        for (int a = 0; a < 4; a++) begin
          logic [15:0] pa, da, wa;
          pa = das[(a + 3) % 4] ^ 16'(c * 16'h0101);
          da = das[a] | 16'(c);
          wa = das[(a + 2) % 4] ^ 16'h0041;
          run_seq(c[2], c[1], c[0], pa, da, wa, 16'(16'h1234 + a * 16'h1111 + c),
                  a == 3, (a == 1) && g[0], 0, 8'h0);
        end
      end
    end
    // R6: window written in the accept cycle applies to the next sequence only
    set_greg(8'h00);
    run_seq(0, 1, 1, 16'h0, 16'hFF00, 16'hC000, 16'hBEEF, 0, 0, 1, 8'h80);
    run_seq(0, 1, 1, 16'h0, 16'hFF00, 16'hC000, 16'hBEEF, 0, 0, 0, 8'h0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule